// File: doc/BRIEF.md
# Three-Operand ALU Stage with Register-Zero Substitution

This block is the 24-bit arithmetic and logic stage of a small fixed-point DSP. It receives the decoded opcode, the three register selectors of an instruction, the two register values read for it and a 16-bit immediate. Selector value zero never names a real register. As the second source it stands for the immediate. As the first source it stands for the constant zero. As the destination it turns the operation into a compare: the result is computed and the flags are updated, but no write is requested.

The result and the write enable are combinational. The condition flags are held in a register that loads at the clock edge after each add, subtract or logic operation. Conditional assignments read one of these stored flags, picked by a 3-bit selector. Opcodes outside the two ALU groups belong to other units, and the stage leaves them alone.

Top module: `alu24_zsub`

## Requirements
- R1: When `sel_t` is 0, the second operand is the immediate widened as `{imm, 8'h00}`. Otherwise it is `rt_val`.
- R2: When `sel_s` is 0, the first operand is zero. Otherwise it is `rs_val`. This applies together with R1.
- R3: When `sel_d` is 0, `wr_en` stays low, but the flags still update as they would for any other destination.
- R4: Opcode 4'b1000 gives A+B and 4'b1001 gives A-B, both modulo 2^24. `wr_en` is high when `sel_d` is not zero.
- R5: Opcode 4'b1100 gives A AND B, 4'b1101 gives A OR B, 4'b1110 gives NOT(A OR B) and 4'b1111 gives A XOR B.
- R6: Opcode 4'b1010 gives B and 4'b1011 gives -B. These conditional assignments raise `wr_en` only when `flags[flag_sel]` is 1 and `sel_d` is not zero. They never change the flags.
- R7: The `flags` bits are, from bit 0 up: eq, ne, ov, nv, ge, gt, le, lt. eq is set when the result is zero and ne is its inverse. With n = result[23] XOR ov: ge = !n, gt = !n && !eq, le = n || eq, lt = n. The flags load one clock edge after an operation with opcode 4'b1000, 4'b1001 or 4'b11xx is presented.
- R8: ov is set when the signed add or subtract leaves the 24-bit range, and nv is its inverse. Logic operations clear ov.
- R9: Opcodes 4'b0xxx hold `wr_en` low, drive `result` to 0 and leave the flags unchanged.
- R10: After reset, `flags` is 8'h59, which is the flag set of a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation code |
| sel_d | input | 4 | Destination selector; 0 means compare only |
| sel_s | input | 4 | First source selector; 0 means zero |
| sel_t | input | 4 | Second source selector; 0 means immediate |
| flag_sel | input | 3 | Flag index used by conditional assignments |
| rs_val | input | 24 | Value read for the first source |
| rt_val | input | 24 | Value read for the second source |
| imm | input | 16 | Q1.15 immediate |
| result | output | 24 | Operation result |
| wr_en | output | 1 | Register write request |
| flags | output | 8 | Stored condition flags |

## Verification
`result` and `wr_en` are due in the same cycle as the inputs that produce them. The bench drives on the falling edge and checks them 1 ns later, before the next rising edge. The flags are due one rising edge after the operation. The bench checks them 1 ns after that edge, against a model flag register that it updates from its own reference function. Conditional assignments are scored against this modelled flag state, so an error in the flag register also shows up in the write-enable checks.

// File: rtl/alu24_zsub.sv
module alu24_zsub #(
  parameter int W  = 24,
  parameter int IW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   opcode,
  input  logic [3:0]   sel_d,
  input  logic [3:0]   sel_s,
  input  logic [3:0]   sel_t,
  input  logic [2:0]   flag_sel,
  input  logic [W-1:0] rs_val,
  input  logic [W-1:0] rt_val,
  input  logic [IW-1:0] imm,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [7:0]   flags
);
  localparam int PAD = W - IW;
  localparam logic [7:0] FLAGS_RST = 8'h59;

  logic [W-1:0] k_ext, op_a, op_b;
  logic is_alu, is_cond, upd, ovf, flag_hit;
  logic zf, nf;
  logic [7:0] flags_nxt;

  assign k_ext = {imm, {PAD{1'b0}}};
  assign op_a  = (sel_s == 4'd0) ? '0 : rs_val;
  assign op_b  = (sel_t == 4'd0) ? k_ext : rt_val;

  assign is_alu  = opcode[3];
  assign is_cond = (opcode[3:2] == 2'b10) & opcode[1];
  assign upd     = is_alu & ~is_cond;

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (opcode)
      4'b1000: begin
        result = op_a + op_b;
        ovf    = (op_a[W-1] == op_b[W-1]) & (result[W-1] != op_a[W-1]);
      end
      4'b1001: begin
        result = op_a - op_b;
        ovf    = (op_a[W-1] != op_b[W-1]) & (result[W-1] != op_a[W-1]);
      end
      4'b1010: result = op_b;
      4'b1011: result = -op_b;
      4'b1100: result = op_a & op_b;
      4'b1101: result = op_a | op_b;
      4'b1110: result = ~(op_a | op_b);
      4'b1111: result = op_a ^ op_b;
      default: result = '0;
    endcase
  end

  assign flag_hit = flags[flag_sel];
  assign wr_en    = is_alu & (sel_d != 4'd0) & (~is_cond | flag_hit);

  assign zf = (result == '0);
  assign nf = result[W-1] ^ ovf;
  assign flags_nxt = {nf, nf | zf, ~nf & ~zf, ~nf, ~ovf, ovf, ~zf, zf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= FLAGS_RST;
    else if (upd) flags <= flags_nxt;
  end

  a_r3_no_write_to_r0: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_d == 4'd0) |-> !wr_en);
  a_r9_ctrl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !opcode[3] |-> (!wr_en && result == '0));
  a_r9_ctrl_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !opcode[3] |=> $stable(flags));
  a_r6_cond_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    is_cond |=> $stable(flags));
  a_r7_eq_ne_pair: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] != flags[1]);
  a_r7_ge_lt_pair: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] != flags[7]);
  a_r8_ov_nv_pair: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] != flags[3]);
  a_r8_logic_clears_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode[3:2] == 2'b11) |=> !flags[2]);
endmodule

// File: tb/tb_alu24_zsub.sv
`timescale 1ns/100ps
module tb_alu24_zsub;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] opcode = '0, sel_d = '0, sel_s = '0, sel_t = '0;
  logic [2:0] flag_sel = '0;
  logic [23:0] rs_val = '0, rt_val = '0;
  logic [15:0] imm = '0;
  logic [23:0] result;
  logic wr_en;
  logic [7:0] flags;

  int checks = 0, failures = 0;
  logic [7:0] mflags;

  alu24_zsub dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .sel_d(sel_d),
    .sel_s(sel_s), .sel_t(sel_t), .flag_sel(flag_sel), .rs_val(rs_val),
    .rt_val(rt_val), .imm(imm), .result(result), .wr_en(wr_en), .flags(flags));

  always #2 clk = ~clk;

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  function automatic longint sx(input logic [23:0] v);
    return v[23] ? longint'(v) - 64'sd16777216 : longint'(v);
  endfunction

  task automatic ref_op(output logic [23:0] r, output bit we, output bit upd, output logic [7:0] nf);
    logic [23:0] a, b;
    longint s;
    bit ov, z, n;
    a = (sel_s == 0) ? 24'd0 : rs_val;                  // R2
    b = (sel_t == 0) ? {imm, 8'h00} : rt_val;           // R1
    ov = 0; upd = 0; we = 0; r = '0;
    case (opcode)
      4'h8: begin s = sx(a) + sx(b); r = s[23:0]; ov = (s > 8388607) || (s < -8388608); upd = 1; end
      4'h9: begin s = sx(a) - sx(b); r = s[23:0]; ov = (s > 8388607) || (s < -8388608); upd = 1; end
      4'hA: r = b;
      4'hB: r = 24'd0 - b;
      4'hC: begin r = a & b; upd = 1; end
      4'hD: begin r = a | b; upd = 1; end
      4'hE: begin r = ~(a | b); upd = 1; end
      4'hF: begin r = a ^ b; upd = 1; end
      default: r = '0;
    endcase
    if (opcode[3] && sel_d != 0)
      we = (opcode[3:1] == 3'b101) ? mflags[flag_sel] : 1'b1;
    z = (r == 0); n = r[23] ^ ov;
    nf[0] = z; nf[1] = !z; nf[2] = ov; nf[3] = !ov;
    nf[4] = !n; nf[5] = !n && !z; nf[6] = n || z; nf[7] = n;
  endtask

  task automatic run(input logic [3:0] op, input logic [3:0] d, input logic [3:0] s, input logic [3:0] t,
                     input logic [2:0] fs, input logic [23:0] rs, input logic [23:0] rt, input logic [15:0] k,
                     input string req);
    logic [23:0] er; bit ew, eu; logic [7:0] ef;
    @(negedge clk);
    opcode = op; sel_d = d; sel_s = s; sel_t = t; flag_sel = fs; rs_val = rs; rt_val = rt; imm = k;
    #1;
    ref_op(er, ew, eu, ef);
    chk(result === er, {req, " result"}, {8'h0, result}, {8'h0, er});
    chk(wr_en === ew, {req, " wr_en"}, {31'h0, wr_en}, {31'h0, ew});
    @(posedge clk); #1;
    if (eu) mflags = ef;
    chk(flags === mflags, {req, " flags"}, {24'h0, flags}, {24'h0, mflags});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mflags = 8'h59;
    #5;
    chk(flags === 8'h59, "R10 reset", {24'h0, flags}, 32'h59);
    @(negedge clk); rst_n = 1'b1;

    run(4'h8, 4'd1, 4'd2, 4'd3, 3'd0, 24'h7FFFFF, 24'h000001, 16'h0, "R8 add overflow");
    run(4'h9, 4'd1, 4'd2, 4'd3, 3'd0, 24'h800000, 24'h000001, 16'h0, "R8 sub overflow");
    run(4'h8, 4'd1, 4'd0, 4'd0, 3'd0, 24'h123456, 24'h654321, 16'h8000, "R1 R2 zero plus K");
    run(4'hB, 4'd2, 4'd0, 4'd0, 3'd3, 24'h0, 24'h0, 16'h8000, "R6 minus K taken");
    run(4'h9, 4'd0, 4'd4, 4'd5, 3'd0, 24'h000010, 24'h000010, 16'h0, "R3 compare equal");
    run(4'hA, 4'd3, 4'd1, 4'd7, 3'd1, 24'h1, 24'h00ABCD, 16'h0, "R6 cond not taken");
    run(4'hA, 4'd3, 4'd1, 4'd7, 3'd0, 24'h1, 24'h00ABCD, 16'h0, "R6 cond taken");
    run(4'hE, 4'd5, 4'd0, 4'd0, 3'd0, 24'hFFFFFF, 24'h0, 16'h1234, "R5 not K");
    run(4'hF, 4'd5, 4'd6, 4'd7, 3'd0, 24'hF0F0F0, 24'h0FF00F, 16'h0, "R5 xor");
    run(4'h3, 4'd5, 4'd6, 4'd7, 3'd0, 24'h7FFFFF, 24'h7FFFFF, 16'hFFFF, "R9 control ignored");
    run(4'h5, 4'd5, 4'd6, 4'd0, 3'd0, 24'h000001, 24'h000001, 16'h0001, "R9 mac ignored");
    run(4'h9, 4'd7, 4'd1, 4'd0, 3'd0, 24'h000100, 24'h0, 16'h0002, "R4 sub K");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] d, s, t;
      d = ($urandom % 4 == 0) ? 4'd0 : 4'($urandom);
      s = ($urandom % 4 == 0) ? 4'd0 : 4'($urandom);
      t = ($urandom % 4 == 0) ? 4'd0 : 4'($urandom);
      run(4'($urandom), d, s, t, 3'($urandom), 24'($urandom), 24'($urandom), 16'($urandom),
          "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule